// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block drives one half-bridge leg. A prescaler divides the system clock into a timer tick. An up-counter steps on each tick from zero to a programmable top value and then returns to zero, which gives the switching period. The counter is compared with a programmable threshold to form a raw pulse. That raw pulse is then split into a high-side gate signal and a low-side gate signal. At every change of the raw pulse, both gates are held off for a programmable number of timer ticks, so the switch that is turning off has time to stop conducting before its partner turns on.

Software writes the prescaler, top, threshold and dead-band values through a single write port, one value per write. Each value goes into a shadow copy first. The running copy is refreshed only when the counter wraps, so a duty change never tears a period. While the generator is disabled, the running copy follows the shadow copy directly. A one-clock strobe marks the start of each period, so a controller can align its next update with the switching period.

Top module: `cpwm_leg`

## Requirements
- R1: While `rst` is high, both gate outputs and `period_start` are low. From the first clock edge at which `en` is sampled low, both gates and `period_start` stay low and all counters are cleared.
- R2: With prescaler value P, the timer ticks once every P+1 clocks. P=0 means a tick on every clock.
- R3: With top value TOP, the counter runs 0..TOP and wraps to 0, so one period lasts (P+1)*(TOP+1) clocks. `period_start` is high for exactly one clock at the start of each period, while the counter is 0.
- R4: The raw pulse is high while the counter is less than or equal to the threshold CMP, and low otherwise. If CMP >= TOP, the raw pulse never goes low and `gate_hi` stays on for the whole period.
- R5: `gate_hi` follows the raw pulse and `gate_lo` follows its complement, each one timer tick behind. The two gates are never high in the same clock.
- R6: After every change of the raw pulse, both gates are low for DT timer ticks, where DT is the dead-band value, before the new side turns on. DT=0 switches sides on the same edge. In steady state with CMP < TOP, `gate_hi` is high for (CMP+1-DT)*(P+1) clocks per period and `gate_lo` for (TOP-CMP-DT)*(P+1) clocks.
- R7: A raw phase of DT ticks or fewer produces no pulse at all on its gate, rather than a shortened one.
- R8: The write selector picks the target value: 0 prescaler, 1 top, 2 threshold, 3 dead-band. Writes land in a shadow copy. The running copy takes them at the next counter wrap, or at once while disabled. A period already in progress keeps its old values.
- R9: After enable, both gates stay low until the first timer tick and then for DT further ticks. The first gate turned on is therefore `gate_hi`, in the clock numbered (P+1)*(DT+1) after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the counters and forces both gates off |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Target value select (0 prescaler, 1 top, 2 threshold, 3 dead-band) |
| wr_data | input | 16 | Value to write; narrower targets take the low bits |
| gate_hi | output | 1 | High-side switch drive |
| gate_lo | output | 1 | Low-side switch drive |
| period_start | output | 1 | One-clock strobe at the start of each period |

## Verification
Assertions check on every cycle that the two gates never overlap, that the gates drop one edge after `en` falls, that the counter stays within the running top value and moves only on a timer tick, that the strobe coincides with a zero count, and that the running configuration holds between wraps. Only the bench scenarios can show the timing relations: period length, per-period on-times with the dead-band subtracted, pulse suppression for short phases, the one-period lag of a shadowed write, and the enable start-up delay.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int unsigned CNT_W = 16;
    localparam int unsigned PSC_W = 8;
    localparam int unsigned DT_W  = 8;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_PSC = 2'd0,
        SEL_TOP = 2'd1,
        SEL_CMP = 2'd2,
        SEL_DT  = 2'd3
    } sel_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] top;
        logic [CNT_W-1:0] cmp;
        logic [DT_W-1:0]  dt;
    } cfg_t;

    localparam cfg_t CFG_RST = '{psc: '0, top: '0, cmp: '0, dt: '0};

    function automatic cfg_t cfg_write(cfg_t c, sel_e s, logic [CNT_W-1:0] d);
        cfg_t r;
        r = c;
        case (s)
            SEL_PSC: r.psc = d[PSC_W-1:0];
            SEL_TOP: r.top = d;
            SEL_CMP: r.cmp = d;
            SEL_DT:  r.dt  = d[DT_W-1:0];
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpwm_cfg_regs.sv
module cpwm_cfg_regs
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  sel_e             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output cfg_t             act
);

    cfg_t shadow_q, shadow_d, act_q;

    always_comb begin
        shadow_d = shadow_q;
        if (wr_en) shadow_d = cfg_write(shadow_q, wr_sel, wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= CFG_RST;
            act_q    <= CFG_RST;
        end else begin
            shadow_q <= shadow_d;
            if (load) act_q <= shadow_d;
        end
    end

    assign act = act_q;

    // R8: running configuration only changes at a load point
    p_active_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act_q));

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  cfg_t             act,
    output logic             tick,
    output logic             wrap,
    output logic             raw,
    output logic             strobe
);

    logic [PSC_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             strobe_q;

    assign tick = en && (pre_q == act.psc);
    assign wrap = tick && (cnt_q == act.top);
    assign raw  = (cnt_q <= act.cmp);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q    <= '0;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            pre_q    <= tick ? '0 : pre_q + 1'b1;
            strobe_q <= wrap;
            if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign strobe = strobe_q;

    // R3: counter never passes the running top value
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= act.top);

    // R2: counter only steps on a timer tick
    p_cnt_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt_q));

    // R3: strobe coincides with the first count of a period
    p_strobe_zero_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> (cnt_q == '0));

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic            raw,
    input  logic [DT_W-1:0] dt,
    output logic            gate_hi,
    output logic            gate_lo
);

    logic            armed_q;
    logic            lvl_q;
    logic [DT_W-1:0] dcnt_q;
    logic            settled;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed_q <= 1'b0;
            lvl_q   <= 1'b0;
            dcnt_q  <= '0;
        end else if (tick) begin
            if (!armed_q || (raw != lvl_q)) begin
                armed_q <= 1'b1;
                lvl_q   <= raw;
                dcnt_q  <= dt;
            end else if (dcnt_q != '0) begin
                dcnt_q  <= dcnt_q - 1'b1;
            end
        end
    end

    assign settled = armed_q && (dcnt_q == '0);
    assign gate_hi = settled && lvl_q;
    assign gate_lo = settled && !lvl_q;

    // R5: the two switches are never driven together
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    // R1: gates drop on the edge after enable is seen low
    p_off_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate_hi && !gate_lo));

endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             period_start
);

    cfg_t act;
    logic tick, wrap, raw;

    cpwm_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (sel_e'(wr_sel)),
        .wr_data (wr_data),
        .load    (!en || wrap),
        .act     (act)
    );

    cpwm_timebase u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .act    (act),
        .tick   (tick),
        .wrap   (wrap),
        .raw    (raw),
        .strobe (period_start)
    );

    cpwm_deadband u_db (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (tick),
        .raw     (raw),
        .dt      (act.dt),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

endmodule

// File: tb/cpwm_leg_bench.sv
`timescale 1ns/1ps
module cpwm_leg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        gate_hi, gate_lo, period_start;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cpwm_leg u_cpwm_leg (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .period_start(period_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_period(int psc, int top);
        return (psc + 1) * (top + 1);
    endfunction

    function automatic int exp_hi(int psc, int top, int cmp, int dt);
        int h;
        if (cmp >= top) return (top + 1) * (psc + 1);
        h = cmp + 1;
        return (h > dt) ? (h - dt) * (psc + 1) : 0;
    endfunction

    function automatic int exp_lo(int psc, int top, int cmp, int dt);
        int l;
        if (cmp >= top) return 0;
        l = top - cmp;
        return (l > dt) ? (l - dt) * (psc + 1) : 0;
    endfunction

    task automatic wr(input int sel, input int val);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = val[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int psc, input int top, input int cmp, input int dt);
        wr(0, psc); wr(1, top); wr(2, cmp); wr(3, dt);
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (!period_start) @(negedge clk);
    endtask

    task automatic measure(output int plen, output int hc, output int lc, output int ov);
        wait_strobe();
        plen = 0; hc = 0; lc = 0; ov = 0;
        do begin
            plen++;
            hc += int'(gate_hi);
            lc += int'(gate_lo);
            ov += int'(gate_hi && gate_lo);
            @(negedge clk);
        end while (!period_start);
    endtask

    task automatic run_case(input int psc, input int top, input int cmp, input int dt, input string nm);
        int plen, hc, lc, ov;
        en = 1'b0;
        @(negedge clk);
        setup(psc, top, cmp, dt);
        en = 1'b1;
        for (int i = 0; i < dt + 3; i++) wait_strobe();
        measure(plen, hc, lc, ov);
        check({nm, " R2/R3 period clocks"}, plen, exp_period(psc, top));
        check({nm, " R4/R6/R7 gate_hi on-clocks"}, hc, exp_hi(psc, top, cmp, dt));
        check({nm, " R5/R6 gate_lo on-clocks"}, lc, exp_lo(psc, top, cmp, dt));
        check({nm, " R5 overlap clocks"}, ov, 0);
    endtask

    initial begin
        #900000;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int plen, hc, lc, ov, n, lo_seen;
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 gate_hi in reset", int'(gate_hi), 0);
        check("R1 gate_lo in reset", int'(gate_lo), 0);
        check("R1 strobe in reset", int'(period_start), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 gate_lo disabled after reset", int'(gate_lo), 0);

        // directed cases
        run_case(1, 9, 3, 2, "basic");
        run_case(0, 9, 1, 3, "R7 short high phase suppressed");
        run_case(0, 9, 7, 2, "R7 short low phase suppressed");
        run_case(2, 6, 6, 1, "R4 compare equals top");
        run_case(0, 5, 9, 2, "R4 compare above top");
        run_case(0, 7, 3, 0, "R6 zero dead-band");
        run_case(3, 0, 0, 0, "R2 top zero");

        // R8: shadowed write keeps the running period intact
        en = 1'b0; @(negedge clk);
        setup(0, 9, 6, 1);
        en = 1'b1;
        for (int i = 0; i < 4; i++) wait_strobe();
        wait_strobe();
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'd2;
        plen = 0; hc = 0;
        do begin
            plen++;
            hc += int'(gate_hi);
            @(negedge clk);
            wr_en = 1'b0;
        end while (!period_start);
        check("R8 period in progress keeps old threshold", hc, exp_hi(0, 9, 6, 1));
        wait_strobe();
        measure(plen, hc, lc, ov);
        check("R8 new threshold after wrap", hc, exp_hi(0, 9, 2, 1));

        // R1: disable mid-run
        en = 1'b0;
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            n += int'(gate_hi) + int'(gate_lo) + int'(period_start);
            @(negedge clk);
        end
        check("R1 outputs low while disabled", n, 0);

        // R9: start-up delay after enable
        setup(2, 15, 10, 3);
        en = 1'b1;
        n = 0; lo_seen = 0;
        do begin
            @(negedge clk);
            n++;
            lo_seen += int'(gate_lo);
        end while (!gate_hi && n < 200);
        check("R9 clocks until first gate_hi", n, 12);
        check("R9 gate_lo stays off before first gate_hi", lo_seen, 0);

        // constrained random configurations
        for (int k = 0; k < 24; k++) begin
            int p, t, c, d;
            p = int'($urandom % 4);
            t = int'($urandom % 21);
            c = int'($urandom % 24);
            d = int'($urandom % 6);
            run_case(p, t, c, d, $sformatf("rand%0d", k));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule